// File: doc/BRIEF.md
# Delay-Slot Branch and Trap Controller

This execute-stage controller serves a processor with a single branch delay slot. When a branch-type operation issues, the controller works out the destination and decides whether the branch is taken. For conditional forms, that decision uses the current T flag. The redirect does not happen at once. It is applied only after the next issued instruction, the delay slot, has executed. At that point a one-cycle redirect pulse carries the new program counter to fetch.

The block also owns three registers. The procedure-return register is written by the subroutine-call forms. The status register is loaded either by a masked direct write or by a return-from-exception restore. The trap-number register is written by the trap operation.

Exceptions are reported as a one-cycle pulse with a 12-bit code. There are three codes: software trap, illegal operation, and slot-illegal operation. The last one covers an illegal operation, trap or branch found in a delay slot. An exception always wins over a delayed branch that is waiting, and that branch is discarded.

Top module: `delay_branch_ctl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `redirect_o`, `exc_valid_o`, `exc_code_o`, `pr_o`, `sr_o` and `tra_o` are all zero.
- R2: Conditional branches latch `disp_i` as the destination. Op 1 (branch-if-true) is taken only when `t_i` is 1, and op 2 (branch-if-false) only when `t_i` is 0. A branch that is not taken gives no redirect once its slot has executed.
- R3: Unconditional branches are always taken. Op 3 goes to `disp_i`, op 4 to `disp_i + reg_i`, and op 8 to `reg_i`.
- R4: Subroutine calls go to these destinations: op 5 to `disp_i`, op 6 to `disp_i + reg_i`, op 7 to `reg_i`. Each call also loads `link_pc_i` into `pr_o`, visible on the cycle after issue.
- R5: Op 9 (return from subroutine) is always taken, with `pr_o` as the destination.
- R6: Op 10 (return from exception) copies `ssr_i` into `sr_o` and is taken to `spc_i`.
- R7: Redirect timing is fixed. The issue cycle of a branch produces no redirect. Cycles with `issue_i` low do not consume the slot. The next issued operation that is not faulting executes the slot, and on the cycle after it `redirect_o` is high for exactly one cycle with `redirect_pc_o` equal to the latched destination, if the branch was taken.
- R8: Op 11 (trap), outside a slot, raises code 0x160 and loads `tra_o` with `disp_i[7:0]` shifted left by two.
- R9: Op 12 and the unused codes 14 and 15 are illegal. Outside a slot they raise code 0x180.
- R10: A branch (ops 1-10), trap or illegal op issued while a slot is pending raises code 0x1A0. It writes neither `pr_o`, `sr_o` nor `tra_o`, and the pending branch is cancelled, so no redirect follows.
- R11: Op 13 loads `sr_o` with `reg_i & 32'h700083F3`. Op 0 is an ordinary instruction that touches no register here.
- R12: `exc_valid_o` is high only on the cycle after a faulting issue. `exc_code_o` keeps the last code raised until the next exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | An operation executes this cycle |
| op_i | input | 4 | Operation select (codes in requirements) |
| disp_i | input | 32 | Displacement destination / trap immediate |
| reg_i | input | 32 | Register operand |
| t_i | input | 1 | Current T flag |
| link_pc_i | input | 32 | Return address written by calls |
| ssr_i | input | 32 | Saved status |
| spc_i | input | 32 | Saved program counter |
| redirect_o | output | 1 | One-cycle redirect pulse |
| redirect_pc_o | output | 32 | Redirect destination |
| pr_o | output | 32 | Procedure-return register |
| sr_o | output | 32 | Status register |
| exc_valid_o | output | 1 | One-cycle exception pulse |
| exc_code_o | output | 12 | Last exception code |
| tra_o | output | 32 | Trap-number register |

## Verification
Directed cases try each conditional form with T at both values, which separates the taken and not-taken paths. They also put idle cycles between a branch and its slot, to show that idle cycles do not consume the slot. Further directed cases issue a trap, an illegal op and a branch inside a pending slot. These show that slot-illegal differs from the plain codes, and that the fault cancels the redirect. Status writes use all-ones and random operands, which exposes the mask. Random streams of all sixteen op codes, with random operands and issue gaps, are compared against a reference model in the bench. This covers back-to-back exceptions and chained branch/slot pairs.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  typedef enum logic [3:0] {
    OP_PLAIN = 4'd0,
    OP_BT    = 4'd1,
    OP_BF    = 4'd2,
    OP_BRA   = 4'd3,
    OP_BRAR  = 4'd4,
    OP_CALL  = 4'd5,
    OP_CALLR = 4'd6,
    OP_CALLI = 4'd7,
    OP_JMP   = 4'd8,
    OP_RET   = 4'd9,
    OP_ERET  = 4'd10,
    OP_TRAP  = 4'd11,
    OP_ILL   = 4'd12,
    OP_SRW   = 4'd13
  } op_e;

  localparam int ECODE_W = 12;
  localparam logic [ECODE_W-1:0] EXC_TRAP = 12'h160;
  localparam logic [ECODE_W-1:0] EXC_ILL  = 12'h180;
  localparam logic [ECODE_W-1:0] EXC_SLOT = 12'h1A0;
endpackage

// File: rtl/dbc_target.sv
module dbc_target
  import dbc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] disp_i,
  input  logic [XLEN-1:0] reg_i,
  input  logic [XLEN-1:0] pr_i,
  input  logic [XLEN-1:0] spc_i,
  input  logic            t_i,
  output logic            is_branch_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] target_o
);
  always_comb begin
    is_branch_o = 1'b1;
    taken_o     = 1'b1;
    link_we_o   = 1'b0;
    target_o    = disp_i;
    case (op_i)
      OP_BT:    taken_o = t_i;
      OP_BF:    taken_o = ~t_i;
      OP_BRA:   ;
      OP_BRAR:  target_o = disp_i + reg_i;
      OP_CALL:  link_we_o = 1'b1;
      OP_CALLR: begin link_we_o = 1'b1; target_o = disp_i + reg_i; end
      OP_CALLI: begin link_we_o = 1'b1; target_o = reg_i; end
      OP_JMP:   target_o = reg_i;
      OP_RET:   target_o = pr_i;
      OP_ERET:  target_o = spc_i;
      default: begin
        is_branch_o = 1'b0;
        taken_o     = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dbc_exc.sv
module dbc_exc
  import dbc_pkg::*;
#(
  parameter int IMM_W = 8
) (
  input  logic [3:0]         op_i,
  input  logic               in_slot_i,
  input  logic               is_branch_i,
  output logic               fire_o,
  output logic               tra_we_o,
  output logic [ECODE_W-1:0] code_o
);
  logic is_trap, is_ill;

  assign is_trap = (op_i == OP_TRAP);
  assign is_ill  = (op_i == OP_ILL) || (op_i > OP_SRW);

  always_comb begin
    fire_o   = 1'b0;
    tra_we_o = 1'b0;
    code_o   = '0;
    if (in_slot_i && (is_branch_i || is_trap || is_ill)) begin
      fire_o = 1'b1;
      code_o = EXC_SLOT;
    end else if (is_trap) begin
      fire_o   = 1'b1;
      tra_we_o = 1'b1;
      code_o   = EXC_TRAP;
    end else if (is_ill) begin
      fire_o = 1'b1;
      code_o = EXC_ILL;
    end
  end
endmodule

// File: rtl/dbc_slot.sv
module dbc_slot #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_i,
  input  logic            exc_i,
  input  logic            is_branch_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] target_i,
  output logic            pending_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o
);
  logic            taken_q;
  logic [XLEN-1:0] target_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_o     <= 1'b0;
      taken_q       <= 1'b0;
      target_q      <= '0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      redirect_o <= 1'b0;
      if (issue_i) begin
        if (exc_i) begin
          pending_o <= 1'b0;
          taken_q   <= 1'b0;
        end else if (pending_o) begin
          pending_o     <= 1'b0;
          redirect_o    <= taken_q;
          redirect_pc_o <= target_q;
        end else if (is_branch_i) begin
          pending_o <= 1'b1;
          taken_q   <= taken_i;
          target_q  <= target_i;
        end
      end
    end
  end
endmodule

// File: rtl/delay_branch_ctl.sv
module delay_branch_ctl
  import dbc_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter int          IMM_W   = 8,
  parameter logic [31:0] SR_MASK = 32'h700083F3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               issue_i,
  input  logic [3:0]         op_i,
  input  logic [XLEN-1:0]    disp_i,
  input  logic [XLEN-1:0]    reg_i,
  input  logic               t_i,
  input  logic [XLEN-1:0]    link_pc_i,
  input  logic [XLEN-1:0]    ssr_i,
  input  logic [XLEN-1:0]    spc_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    pr_o,
  output logic [XLEN-1:0]    sr_o,
  output logic               exc_valid_o,
  output logic [ECODE_W-1:0] exc_code_o,
  output logic [XLEN-1:0]    tra_o
);
  localparam int TRA_PAD = XLEN - IMM_W - 2;
  localparam logic [XLEN-1:0] SR_KEEP = XLEN'(SR_MASK);

  logic               is_branch, taken, link_we, pending;
  logic               exc_fire, tra_we;
  logic [XLEN-1:0]    target;
  logic [ECODE_W-1:0] exc_code;
  logic               commit;

  dbc_target #(.XLEN(XLEN)) u_tgt (
    .op_i(op_i), .disp_i(disp_i), .reg_i(reg_i), .pr_i(pr_o),
    .spc_i(spc_i), .t_i(t_i), .is_branch_o(is_branch), .taken_o(taken),
    .link_we_o(link_we), .target_o(target)
  );

  dbc_exc #(.IMM_W(IMM_W)) u_exc (
    .op_i(op_i), .in_slot_i(pending), .is_branch_i(is_branch),
    .fire_o(exc_fire), .tra_we_o(tra_we), .code_o(exc_code)
  );

  dbc_slot #(.XLEN(XLEN)) u_slot (
    .clk(clk), .rst(rst), .issue_i(issue_i), .exc_i(exc_fire),
    .is_branch_i(is_branch), .taken_i(taken), .target_i(target),
    .pending_o(pending), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  assign commit = issue_i & ~exc_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_o        <= '0;
      sr_o        <= '0;
      tra_o       <= '0;
      exc_valid_o <= 1'b0;
      exc_code_o  <= '0;
    end else begin
      exc_valid_o <= issue_i & exc_fire;
      if (issue_i && exc_fire) exc_code_o <= exc_code;
      if (issue_i && tra_we) tra_o <= {{TRA_PAD{1'b0}}, disp_i[IMM_W-1:0], 2'b00};
      if (commit && link_we) pr_o <= link_pc_i;
      if (commit && op_i == OP_SRW) sr_o <= reg_i & SR_KEEP;
      else if (commit && op_i == OP_ERET) sr_o <= ssr_i;
    end
  end
endmodule

// File: rtl/delay_branch_ctl_chk.sv
module delay_branch_ctl_chk #(
  parameter int          XLEN    = 32,
  parameter logic [31:0] SR_MASK = 32'h700083F3
) (
  input logic            clk,
  input logic            rst,
  input logic            issue,
  input logic [3:0]      op,
  input logic [XLEN-1:0] disp,
  input logic            pending,
  input logic            exc_fire,
  input logic            redirect,
  input logic            exc_valid,
  input logic [11:0]     exc_code,
  input logic [XLEN-1:0] sr,
  input logic [XLEN-1:0] tra
);
  localparam logic [XLEN-1:0] SR_KEEP = XLEN'(SR_MASK);

  assert_no_redirect_on_fault_R10: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> !redirect);

  assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_code == 12'h160 || exc_code == 12'h180 || exc_code == 12'h1A0));

  assert_sr_masked_R11: assert property (@(posedge clk) disable iff (rst)
    (issue && op == 4'd13 && !exc_fire) |=> ((sr & ~SR_KEEP) == '0));

  assert_trap_value_R8: assert property (@(posedge clk) disable iff (rst)
    (issue && op == 4'd11 && !pending) |=>
      (exc_valid && exc_code == 12'h160 &&
       tra == {{(XLEN-10){1'b0}}, $past(disp[7:0]), 2'b00}));

  assert_redirect_after_slot_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(redirect) |-> ($past(pending) && $past(issue)));
endmodule

bind delay_branch_ctl delay_branch_ctl_chk #(.XLEN(XLEN), .SR_MASK(SR_MASK)) u_chk (
  .clk(clk), .rst(rst), .issue(issue_i), .op(op_i), .disp(disp_i),
  .pending(pending), .exc_fire(exc_fire), .redirect(redirect_o),
  .exc_valid(exc_valid_o), .exc_code(exc_code_o), .sr(sr_o), .tra(tra_o)
);

// File: tb/sim_delay_branch_ctl.sv
`timescale 1ns/1ps
module sim_delay_branch_ctl;
  localparam logic [31:0] MASK = 32'h700083F3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] disp_i = '0, reg_i = '0, link_pc_i = '0, ssr_i = '0, spc_i = '0;
  logic        t_i = 1'b0;
  logic        redirect_o, exc_valid_o;
  logic [31:0] redirect_pc_o, pr_o, sr_o, tra_o;
  logic [11:0] exc_code_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic        m_pend = 0, m_tk = 0;
  logic [31:0] m_tgt = 0, m_pr = 0, m_sr = 0, m_tra = 0;
  logic [11:0] m_code = 0;
  string       m_tag = "R3";

  always #2.5 clk = ~clk;

  delay_branch_ctl u0 (
    .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i), .disp_i(disp_i),
    .reg_i(reg_i), .t_i(t_i), .link_pc_i(link_pc_i), .ssr_i(ssr_i), .spc_i(spc_i),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .pr_o(pr_o),
    .sr_o(sr_o), .exc_valid_o(exc_valid_o), .exc_code_o(exc_code_o), .tra_o(tra_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [31:0] d, input logic [31:0] r,
                      input logic t, input logic iss);
    logic is_br, trap, ill, tk, exp_red, exp_exc;
    logic [31:0] tgt, exp_pc;
    string tag, etag;
    issue_i = iss; op_i = op; disp_i = d; reg_i = r; t_i = t;
    link_pc_i = $urandom; ssr_i = $urandom; spc_i = $urandom;
    @(posedge clk);
    is_br = (op >= 4'd1 && op <= 4'd10);
    trap  = (op == 4'd11);
    ill   = (op == 4'd12 || op >= 4'd14);
    tk = 1'b1; tgt = d; tag = "R3";
    case (op)
      4'd1: begin tk = t;  tag = "R2"; end
      4'd2: begin tk = !t; tag = "R2"; end
      4'd4: tgt = d + r;
      4'd5: tag = "R4";
      4'd6: begin tgt = d + r; tag = "R4"; end
      4'd7: begin tgt = r; tag = "R4"; end
      4'd8: tgt = r;
      4'd9: begin tgt = m_pr; tag = "R5"; end
      4'd10: begin tgt = spc_i; tag = "R6"; end
      default: ;
    endcase
    exp_red = 0; exp_exc = 0; exp_pc = 0; etag = "R12";
    if (iss) begin
      if (m_pend && (is_br || trap || ill)) begin
        exp_exc = 1; m_code = 12'h1A0; m_pend = 0; etag = "R10";
      end else if (trap) begin
        exp_exc = 1; m_code = 12'h160; m_tra = {22'd0, d[7:0], 2'b00}; etag = "R8";
      end else if (ill) begin
        exp_exc = 1; m_code = 12'h180; etag = "R9";
      end else begin
        if (m_pend) begin
          exp_red = m_tk; exp_pc = m_tgt; m_pend = 0;
        end else if (is_br) begin
          m_pend = 1; m_tk = tk; m_tgt = tgt; m_tag = tag;
        end
        if (op >= 4'd5 && op <= 4'd7) m_pr = link_pc_i;
        if (op == 4'd13) m_sr = r & MASK;
        if (op == 4'd10) m_sr = ssr_i;
      end
    end
    @(negedge clk);
    chk("R7 redirect", 32'(redirect_o), 32'(exp_red));
    if (exp_red) chk({m_tag, " redirect_pc"}, redirect_pc_o, exp_pc);
    chk({etag, " exc_valid"}, 32'(exc_valid_o), 32'(exp_exc));
    chk({etag, " exc_code"}, 32'(exc_code_o), 32'(m_code));
    chk("R4 pr", pr_o, m_pr);
    chk((op == 4'd10) ? "R6 sr" : "R11 sr", sr_o, m_sr);
    chk("R8 tra", tra_o, m_tra);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 redirect", 32'(redirect_o), 0);
    chk("R1 exc", 32'(exc_valid_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pr", pr_o, 0);
    chk("R1 sr", sr_o, 0);
    chk("R1 tra", tra_o, 0);
    chk("R1 code", 32'(exc_code_o), 0);
    // R2 conditional both ways
    step(4'd1, 32'h100, 0, 1'b1, 1); step(4'd0, 0, 0, 0, 1);
    step(4'd1, 32'h104, 0, 1'b0, 1); step(4'd0, 0, 0, 0, 1);
    step(4'd2, 32'h108, 0, 1'b0, 1); step(4'd0, 0, 0, 1, 1);
    step(4'd2, 32'h10C, 0, 1'b1, 1); step(4'd0, 0, 0, 0, 1);
    // R7 idle cycles between branch and slot
    step(4'd4, 32'h200, 32'h30, 0, 1); step(4'd0, 0, 0, 0, 0); step(4'd0, 0, 0, 0, 0);
    step(4'd13, 0, 32'hFFFF_FFFF, 0, 1);
    // R4/R5 call then return
    step(4'd7, 0, 32'h4000, 0, 1); step(4'd0, 0, 0, 0, 1);
    step(4'd9, 0, 0, 0, 1); step(4'd0, 0, 0, 0, 1);
    // R6 return from exception
    step(4'd10, 0, 0, 0, 1); step(4'd0, 0, 0, 0, 1);
    // R8 trap, R9 illegal, R10 faults in slot
    step(4'd11, 32'hAB, 0, 0, 1);
    step(4'd12, 0, 0, 0, 1); step(4'd15, 0, 0, 0, 1);
    step(4'd3, 32'h500, 0, 0, 1); step(4'd11, 32'h5, 0, 0, 1); step(4'd0, 0, 0, 0, 1);
    step(4'd5, 32'h600, 0, 0, 1); step(4'd6, 32'h700, 0, 0, 1); step(4'd0, 0, 0, 0, 1);
    step(4'd8, 0, 32'h800, 0, 1); step(4'd14, 0, 0, 0, 1);
    // random mix
    for (int i = 0; i < 3000; i++)
      step(4'($urandom % 16), $urandom, $urandom, 1'($urandom), ($urandom % 4) != 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule